// File: doc/BRIEF.md
# Programmable Microsecond Interval Timer

This block is a single interval timer that sits behind a small 64-bit register interface. A counter advances by one on every cycle in which the external microsecond strobe is high. Software programs a limit value and three mode controls through one control word: interrupt enable, periodic restart and an immediate reload of the counter to zero. When the counter steps onto the programmed limit, the block records a pending interrupt (if enabled). In periodic mode the counter then starts again from zero. In one-shot mode it parks at the limit.

The pending interrupt drives `irq_o`. It is not cleared by reading. Software acknowledges it by writing any value to a dedicated clear address. The counter can also be written directly, and it reads back zero-extended to the full bus width. Writes take effect on the clock edge at which `bus_wr` is sampled high. Reads are combinational from the addressed register.

Top module: `cnt_limit_timer`

## Requirements
- R1: After reset the count reads 0, the control word reads 0 and `irq_o` is 0.
- R2: The count rises by one at each clock edge where `tick_us` is high and holds when it is low. A write to address 0 loads bits [27:0] of the data into the count. A read of address 0 returns the count in bits [27:0] with all higher bits zero.
- R3: A write to address 1 stores the control word: bit 31 is interrupt enable, bit 29 selects periodic mode, and bits [28:0] are the limit. A read of address 1 returns those fields in place, with bit 30 and bits [63:32] zero.
- R4: A write to address 1 with bit 30 set clears the count to 0 at that edge. The same write with bit 30 clear leaves the count unchanged.
- R5: With a nonzero limit, a tick that moves the count onto the limit is a match. In one-shot mode (bit 29 = 0), the count then stays at the limit, and later ticks neither change it nor cause another match.
- R6: In periodic mode a match loads 0 instead of the limit, so matches recur every `limit` ticks.
- R7: A match sets the pending interrupt only if bit 31 of the stored control word is 1. `irq_o` shows the pending state, and a read of address 2 returns it in bit 0.
- R8: The pending interrupt stays set until a write to address 2. If a match and a clear write fall on the same edge, the match wins.
- R9: A limit of 0, or one that the 28-bit count cannot reach, never matches. The count then wraps from 0x0FFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_us | input | 1 | One-cycle microsecond strobe; advances the count |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | 0 = count, 1 = control/limit, 2 = interrupt clear, 3 = unused |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data of the addressed register |
| irq_o | output | 1 | Pending interrupt |

## Verification
The assertions assume that `tick_us`, `bus_wr` and `bus_addr` are clean synchronous signals and that only one register is written per cycle. The hold and step properties exclude cycles with a write, so that a load or reload never looks like a missing tick. The bench drives every input on the falling edge and lowers the write strobe before it ticks. Only the directed test for simultaneous match and clear deliberately combines a write with a tick, and that write goes to the clear address, which never touches the count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_W   = 64;
  localparam int EN_BIT  = 31;
  localparam int RLD_BIT = 30;
  localparam int PER_BIT = 29;
  localparam int LIM_W   = PER_BIT;   // limit field occupies bits below the periodic bit

  typedef enum logic [1:0] {
    ADDR_COUNT = 2'd0,
    ADDR_LIMIT = 2'd1,
    ADDR_CLEAR = 2'd2,
    ADDR_NONE  = 2'd3
  } tmr_addr_e;

  typedef struct packed {
    logic             ien;
    logic             per;
    logic [LIM_W-1:0] lim;
  } tmr_ctrl_t;

  // Pack the control fields back into the readable word (reload bit always 0).
  function automatic logic [REG_W-1:0] ctrl_word(input tmr_ctrl_t c);
    logic [REG_W-1:0] w;
    w          = '0;
    w[EN_BIT]  = c.ien;
    w[PER_BIT] = c.per;
    w[LIM_W-1:0] = c.lim;
    return w;
  endfunction
endpackage

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output tmr_ctrl_t        ctrl,
  output logic             reload_evt
);
  assign reload_evt = wr_en && wdata[RLD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_en) begin
      ctrl.ien <= wdata[EN_BIT];
      ctrl.per <= wdata[PER_BIT];
      ctrl.lim <= wdata[LIM_W-1:0];
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 28,
  parameter int LIM_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             reload,
  input  logic [LIM_W-1:0] lim,
  input  logic             periodic,
  output logic [CNT_W-1:0] count,
  output logic             match_evt
);
  function automatic logic [CNT_W-1:0] incr(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  function automatic logic equals_lim(input logic [CNT_W-1:0] c,
                                      input logic [LIM_W-1:0] l);
    return (l != '0) && (LIM_W'(c) == l);
  endfunction

  logic parked;
  logic advance;

  assign parked    = !periodic && equals_lim(count, lim);
  assign advance   = tick && !parked;
  assign match_evt = advance && equals_lim(incr(count), lim) && !load_en && !reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (reload)               count <= '0;
    else if (load_en)              count <= load_val;
    else if (match_evt && periodic) count <= '0;
    else if (advance)              count <= incr(count);
  end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pending <= 1'b0;
    else if (set_evt) pending <= 1'b1;
    else if (clr_evt) pending <= 1'b0;
  end
endmodule

// File: rtl/cnt_limit_timer.sv
module cnt_limit_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_us,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [63:0]      bus_wdata,
  output logic [63:0]      bus_rdata,
  output logic             irq_o
);
  tmr_ctrl_t        ctrl;
  logic [CNT_W-1:0] count;
  logic             cnt_wr_evt;
  logic             lim_wr_evt;
  logic             clr_evt;
  logic             reload_evt;
  logic             match_evt;
  logic             irq_set_evt;
  logic             pending;

  assign cnt_wr_evt  = bus_wr && (tmr_addr_e'(bus_addr) == ADDR_COUNT);
  assign lim_wr_evt  = bus_wr && (tmr_addr_e'(bus_addr) == ADDR_LIMIT);
  assign clr_evt     = bus_wr && (tmr_addr_e'(bus_addr) == ADDR_CLEAR);
  assign irq_set_evt = match_evt && ctrl.ien;

  tmr_ctrl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (lim_wr_evt),
    .wdata      (bus_wdata),
    .ctrl       (ctrl),
    .reload_evt (reload_evt)
  );

  tmr_counter #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_us),
    .load_en   (cnt_wr_evt),
    .load_val  (bus_wdata[CNT_W-1:0]),
    .reload    (reload_evt),
    .lim       (ctrl.lim),
    .periodic  (ctrl.per),
    .count     (count),
    .match_evt (match_evt)
  );

  tmr_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (irq_set_evt),
    .clr_evt (clr_evt),
    .pending (pending)
  );

  assign irq_o = pending;

  always_comb begin
    case (tmr_addr_e'(bus_addr))
      ADDR_COUNT: bus_rdata = REG_W'(count);
      ADDR_LIMIT: bus_rdata = ctrl_word(ctrl);
      ADDR_CLEAR: bus_rdata = REG_W'(pending);
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 28,
  parameter int LIM_W = 29
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_us,
  input logic             bus_wr,
  input logic [CNT_W-1:0] count,
  input logic [LIM_W-1:0] lim,
  input logic             per,
  input logic             ien,
  input logic             match_evt,
  input logic             reload_evt,
  input logic             clr_evt,
  input logic             irq_o
);
  AST_CNT_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_us && !bus_wr) |=> $stable(count)); // R2

  AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> (count == '0)); // R4

  AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (!per && lim != '0 && LIM_W'(count) == lim && !bus_wr) |=> $stable(count)); // R5

  AST_PERIODIC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && per) |=> (count == '0)); // R6

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(ien && match_evt)); // R7

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr_evt) |=> irq_o); // R8

  AST_NO_MATCH_ZERO_LIM: assert property (@(posedge clk) disable iff (!rst_n)
    (lim == '0) |-> !match_evt); // R9
endmodule

bind cnt_limit_timer tmr_checker #(.CNT_W(CNT_W), .LIM_W(tmr_pkg::LIM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_us    (tick_us),
  .bus_wr     (bus_wr),
  .count      (count),
  .lim        (ctrl.lim),
  .per        (ctrl.per),
  .ien        (ctrl.ien),
  .match_evt  (match_evt),
  .reload_evt (reload_evt),
  .clr_evt    (clr_evt),
  .irq_o      (irq_o)
);

// File: tb/tb_cnt_limit_timer.sv
module tb_cnt_limit_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_us = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        irq_o;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  cnt_limit_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  localparam logic [63:0] EN  = 64'h8000_0000;
  localparam logic [63:0] RLD = 64'h4000_0000;
  localparam logic [63:0] PER = 64'h2000_0000;

  typedef struct packed {
    logic [63:0] ctl;
    logic [15:0] ticks;
    logic [63:0] cnt;
    logic        irq;
  } vec_t;

  // R5 one-shot, R6 periodic, R7 enable gating, R9 unreachable limits
  localparam vec_t VECS [10] = '{
    '{EN | 64'd5,        16'd3, 64'd3, 1'b0},
    '{EN | 64'd5,        16'd5, 64'd5, 1'b1},
    '{EN | 64'd5,        16'd9, 64'd5, 1'b1},
    '{64'd5,             16'd5, 64'd5, 1'b0},
    '{EN | PER | 64'd4,  16'd4, 64'd0, 1'b1},
    '{EN | PER | 64'd4,  16'd6, 64'd2, 1'b1},
    '{PER | 64'd4,       16'd7, 64'd3, 1'b0},
    '{EN | 64'd0,        16'd7, 64'd7, 1'b0},
    '{EN | PER | 64'd1,  16'd3, 64'd0, 1'b1},
    '{EN | 64'h1000_0000, 16'd4, 64'd4, 1'b0}
  };

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_us = 1'b1;
    repeat (n) @(negedge clk);
    tick_us = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog got=timeout exp=completion");
    finish_run();
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(2'd0, v); check("R1 count", v, 64'd0);
    rd(2'd1, v); check("R1 ctrl", v, 64'd0);
    check("R1 irq", {63'd0, irq_o}, 64'd0);
    rst_n = 1'b1;

    // R3 layout and readback masking
    wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd1, v); check("R3 readback", v, 64'h0000_0000_BFFF_FFFF);
    // R2 count load keeps 28 bits, zero-extended read
    wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd0, v); check("R2 load width", v, 64'h0FFF_FFFF);
    // R4 reload clears count
    wr(2'd0, 64'd100);
    wr(2'd1, RLD | 64'd200);
    rd(2'd0, v); check("R4 reload", v, 64'd0);
    wr(2'd0, 64'd100);
    wr(2'd1, 64'd200);
    rd(2'd0, v); check("R4 no reload", v, 64'd100);
    // R2 no tick no change
    repeat (5) @(negedge clk);
    rd(2'd0, v); check("R2 hold", v, 64'd100);
    ticks(3);
    rd(2'd0, v); check("R2 step", v, 64'd103);

    // vector table
    foreach (VECS[i]) begin
      wr(2'd2, 64'd0);
      wr(2'd1, VECS[i].ctl);
      wr(2'd0, 64'd0);
      ticks(int'(VECS[i].ticks));
      rd(2'd0, v); check($sformatf("R5/R6/R9 vec%0d count", i), v, VECS[i].cnt);
      check($sformatf("R7 vec%0d irq", i), {63'd0, irq_o}, {63'd0, VECS[i].irq});
    end

    // R9 wrap with limit 0
    wr(2'd1, 64'd0);
    wr(2'd0, 64'h0FFF_FFFF);
    ticks(1);
    rd(2'd0, v); check("R9 wrap", v, 64'd0);

    // R7 / R8 pending readback, stickiness, clear
    wr(2'd2, 64'd0);
    wr(2'd1, EN | 64'd2);
    wr(2'd0, 64'd0);
    ticks(2);
    repeat (4) @(negedge clk);
    rd(2'd2, v); check("R7 clear-addr bit0", v, 64'd1);
    check("R8 sticky", {63'd0, irq_o}, 64'd1);
    wr(2'd2, 64'd0);
    check("R8 cleared", {63'd0, irq_o}, 64'd0);

    // R8 match and clear on same edge: match wins
    wr(2'd0, 64'd1);
    @(negedge clk);
    tick_us = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = '0;
    @(negedge clk);
    tick_us = 1'b0; bus_wr = 1'b0;
    check("R8 set wins", {63'd0, irq_o}, 64'd1);
    rd(2'd0, v); check("R5 parked", v, 64'd2);

    finish_run();
  end
endmodule